// File: doc/BRIEF.md
# PWM Time-Base Counter with Chainable Synchronization

This block is the timing heart of one PWM channel. A 16-bit counter runs up, down or up-down against a programmed period, or holds still. Outputs are the count, the current direction, a one-cycle pulse when the count reaches zero and a one-cycle pulse when it reaches the compare-B value. The period and compare-B inputs are buffered and only take effect at a zero crossing, so software may change them at any time without corrupting a running cycle.

Several channels keep in phase by forming a chain. Each counter can reload a programmed phase offset whenever a synchronization event arrives, either from a sync input pulse or from a software strobe. Each channel also drives a sync output whose source can be selected: the incoming sync (pass-through), its own zero crossing, its own compare-B crossing, or nothing. Wiring one channel's sync output to the next channel's sync input makes the second counter follow the first with a fixed offset.

In pass-through selection a software strobe reaches the sync output as well, so it ripples down the whole chain. A software strobe should therefore be issued only once, while the chain is being initialised.

Top module: `tbase_sync_ctr`

## Requirements
- R1: With mode_sel = 0 (up), the count increments by one per clock and goes from the active period value (or anything above it) back to 0; dir_up reads 1.
- R2: With mode_sel = 1 (down), the count decrements by one per clock and goes from 0 to the active period value; dir_up reads 0.
- R3: With mode_sel = 2 (up-down), the count rises to the active period value and then falls back to 0, reversing direction at each end with the step in the new direction taken in the same clock; dir_up gives the direction of the step now being taken (1 = rising).
- R4: With mode_sel = 3 (stop), the count and dir_up hold their values.
- R5: When phase_en is 1 and either sync_in or sw_sync is 1 at a clock edge, the count becomes phase_val at that edge, whatever the mode. Up mode then sets dir_up to 1, down mode sets it to 0, up-down mode takes phase_dir_up, and stop keeps it. With phase_en = 0 both sync sources leave the count untouched.
- R6: sync_sel picks sync_out: 0 = sync_in OR sw_sync (combinational), 1 = zero_evt, 2 = cmpb_evt, 3 = constant 0.
- R7: zero_evt is 1 for exactly the first clock in which count equals 0, and is not raised again until count has left 0 and returned.
- R8: cmpb_evt is 1 for exactly the first clock in which count equals the active compare-B value, with the same once-per-match rule as R7.
- R9: period_in and cmpb_in become active only in a clock in which count is 0, and are used in that clock; in any other clock the last captured values apply.
- R10: During and after reset, before the first active edge, count is 0, dir_up is 1 and zero_evt, cmpb_evt and sync_out are 0. The zero reached by reset raises no event.
- R11: When one instance's sync_out drives a second instance's sync_in and the second has phase_en = 1, the second instance's count equals its phase_val one clock after each sync_out pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Counting mode: 0 up, 1 down, 2 up-down, 3 stop |
| period_in | input | W | Period value, captured at zero crossings |
| cmpb_in | input | W | Compare-B value, captured at zero crossings |
| phase_val | input | W | Count loaded on a synchronization event |
| phase_en | input | 1 | Enables phase loading on sync events |
| phase_dir_up | input | 1 | Direction after a phase load in up-down mode (1 = rising) |
| sync_in | input | 1 | Incoming sync pulse from the previous channel |
| sw_sync | input | 1 | Software-forced sync strobe |
| sync_sel | input | 2 | Sync output source: 0 pass-through, 1 zero, 2 compare-B, 3 off |
| count | output | W | Current counter value |
| dir_up | output | 1 | Current count direction (1 = rising) |
| zero_evt | output | 1 | One-cycle pulse on reaching zero |
| cmpb_evt | output | 1 | One-cycle pulse on reaching compare-B |
| sync_out | output | 1 | Sync pulse for the next channel |

## Verification
On every cycle the assertions check the local stepping rules: the up-mode increment, the stop-mode hold, the up-down reversal at the period, the phase load landing on the edge after a sync, the single-cycle shape of both event pulses, that a zero-sourced sync output only fires at count zero, and that the active period stays fixed away from zero. Whole count sequences need the bench's scenarios. Those scenarios cover a period change made mid-cycle that only takes effect at the next zero, mode switches, a sync ignored while phase loading is off, a software strobe passing through to the sync output, and the phase lock of a downstream instance in a two-stage chain.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_STOP   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'd0,
    SO_ZERO = 2'd1,
    SO_CMPB = 2'd2,
    SO_OFF  = 2'd3
  } sync_src_e;

endpackage

// File: rtl/tbs_shadow.sv
module tbs_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         at_zero,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] cmpb_in,
  output logic [W-1:0] per_eff,
  output logic [W-1:0] cmpb_eff
);

  logic [W-1:0] per_q;
  logic [W-1:0] cmpb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      cmpb_q <= '0;
    end else if (at_zero) begin
      per_q  <= period_in;
      cmpb_q <= cmpb_in;
    end
  end

  // the zero cycle already uses the fresh values
  assign per_eff  = at_zero ? period_in : per_q;
  assign cmpb_eff = at_zero ? cmpb_in   : cmpb_q;

  // R9
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> (at_zero || per_eff == $past(per_eff)));

  // R9
  cmpb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> (at_zero || cmpb_eff == $past(cmpb_eff)));

endmodule

// File: rtl/tbs_counter.sv
module tbs_counter
  import tbs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic [W-1:0] per_eff,
  input  logic [W-1:0] phase_val,
  input  logic         phase_dir_up,
  input  logic         load_evt,
  output logic [W-1:0] cnt_q,
  output logic         up_q
);

  // returns {direction, count} after one normal step
  function automatic logic [W:0] advance(input logic [1:0] md, input logic [W-1:0] c,
                                         input logic up, input logic [W-1:0] p);
    logic         nu;
    logic [W-1:0] nc;
    nu = up;
    nc = c;
    case (md)
      MODE_UP: begin
        nu = 1'b1;
        nc = (c >= p) ? {W{1'b0}} : c + 1'b1;
      end
      MODE_DOWN: begin
        nu = 1'b0;
        nc = (c == '0) ? p : c - 1'b1;
      end
      MODE_UPDOWN: begin
        if (up) begin
          if (c >= p) begin
            nu = 1'b0;
            nc = (c == '0) ? c : c - 1'b1;
          end else begin
            nc = c + 1'b1;
          end
        end else begin
          if (c == '0) begin
            nu = 1'b1;
            nc = (p == '0) ? c : c + 1'b1;
          end else begin
            nc = c - 1'b1;
          end
        end
      end
      default: ;
    endcase
    return {nu, nc};
  endfunction

  function automatic logic dir_after_load(input logic [1:0] md, input logic pd, input logic up);
    case (md)
      MODE_UP:     return 1'b1;
      MODE_DOWN:   return 1'b0;
      MODE_UPDOWN: return pd;
      default:     return up;
    endcase
  endfunction

  logic [W:0] step_res;
  assign step_res = advance(mode_sel, cnt_q, up_q, per_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (load_evt) begin
      cnt_q <= phase_val;
      up_q  <= dir_after_load(mode_sel, phase_dir_up, up_q);
    end else begin
      cnt_q <= step_res[W-1:0];
      up_q  <= step_res[W];
    end
  end

  // R5
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt_q == $past(phase_val));

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_UP && !load_evt && cnt_q < per_eff) |=> cnt_q == W'($past(cnt_q) + 1'b1));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_STOP && !load_evt) |=> ($stable(cnt_q) && $stable(up_q)));

  // R3
  turn_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_UPDOWN && !load_evt && up_q && cnt_q >= per_eff && per_eff != '0) |=> !up_q);

endmodule

// File: rtl/tbs_events.sv
module tbs_events
  import tbs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cmpb_eff,
  input  logic         sync_evt,
  input  logic [1:0]   sync_sel,
  output logic         zero_evt,
  output logic         cmpb_evt,
  output logic         sync_out
);

  logic at_zero, at_cmpb;
  logic zero_seen_q, cmpb_seen_q;

  assign at_zero = (cnt_q == '0);
  assign at_cmpb = (cnt_q == cmpb_eff);

  // seen flags start high so the reset value raises no event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_seen_q <= 1'b1;
      cmpb_seen_q <= 1'b1;
    end else begin
      zero_seen_q <= at_zero;
      cmpb_seen_q <= at_cmpb;
    end
  end

  assign zero_evt = at_zero & ~zero_seen_q;
  assign cmpb_evt = at_cmpb & ~cmpb_seen_q;

  always_comb begin
    case (sync_sel)
      SO_PASS: sync_out = sync_evt;
      SO_ZERO: sync_out = zero_evt;
      SO_CMPB: sync_out = cmpb_evt;
      default: sync_out = 1'b0;
    endcase
  end

  // R7
  zero_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !zero_evt);

  // R8
  cmpb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpb_evt |=> !cmpb_evt);

  // R6
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_sel == SO_ZERO && sync_out) |-> cnt_q == '0);

endmodule

// File: rtl/tbase_sync_ctr.sv
module tbase_sync_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] cmpb_in,
  input  logic [W-1:0] phase_val,
  input  logic         phase_en,
  input  logic         phase_dir_up,
  input  logic         sync_in,
  input  logic         sw_sync,
  input  logic [1:0]   sync_sel,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         zero_evt,
  output logic         cmpb_evt,
  output logic         sync_out
);

  logic         sync_evt;
  logic         load_evt;
  logic         at_zero;
  logic [W-1:0] per_eff;
  logic [W-1:0] cmpb_eff;
  logic [W-1:0] cnt_q;
  logic         up_q;

  assign sync_evt = sync_in | sw_sync;
  assign load_evt = phase_en & sync_evt;
  assign at_zero  = (cnt_q == '0);

  tbs_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .at_zero(at_zero),
    .period_in(period_in), .cmpb_in(cmpb_in),
    .per_eff(per_eff), .cmpb_eff(cmpb_eff)
  );

  tbs_counter #(.W(W)) u_counter (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .per_eff(per_eff),
    .phase_val(phase_val), .phase_dir_up(phase_dir_up), .load_evt(load_evt),
    .cnt_q(cnt_q), .up_q(up_q)
  );

  tbs_events #(.W(W)) u_events (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cmpb_eff(cmpb_eff),
    .sync_evt(sync_evt), .sync_sel(sync_sel),
    .zero_evt(zero_evt), .cmpb_evt(cmpb_evt), .sync_out(sync_out)
  );

  assign count  = cnt_q;
  assign dir_up = up_q;

  // R5
  no_load_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_en && mode_sel == 2'd3) |=> count == $past(count));

endmodule

// File: tb/sim_tbase_sync_ctr.sv
`timescale 1ns/1ps
module sim_tbase_sync_ctr;
  localparam int W = 16;
  localparam logic [W-1:0] PH1 = 16'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]   mode_sel, sync_sel;
  logic [W-1:0] period_in, cmpb_in, phase_val;
  logic         phase_en, phase_dir_up, sync_in, sw_sync;

  logic [W-1:0] cnt0, cnt1;
  logic up0, zev0, cev0, so0, up1, zev1, cev1, so1;

  tbase_sync_ctr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .period_in(period_in),
    .cmpb_in(cmpb_in), .phase_val(phase_val), .phase_en(phase_en),
    .phase_dir_up(phase_dir_up), .sync_in(sync_in), .sw_sync(sw_sync),
    .sync_sel(sync_sel), .count(cnt0), .dir_up(up0), .zero_evt(zev0),
    .cmpb_evt(cev0), .sync_out(so0)
  );

  tbase_sync_ctr #(.W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_sel(2'd0), .period_in(16'd1000),
    .cmpb_in(16'd500), .phase_val(PH1), .phase_en(1'b1),
    .phase_dir_up(1'b1), .sync_in(so0), .sw_sync(1'b0),
    .sync_sel(2'd1), .count(cnt1), .dir_up(up1), .zero_evt(zev1),
    .cmpb_evt(cev1), .sync_out(so1)
  );

  int vectors = 0;
  int miscompares = 0;
  int chain_hits = 0;
  bit done = 1'b0;
  string cur_tag = "R10";

  typedef struct packed {
    logic [W-1:0] c;
    logic u, z, b, s;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];

  // reference state
  logic [W-1:0] m_cnt, m_per, m_cb;
  logic m_up, m_zq, m_cbq;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_up = 1'b1; m_per = '0; m_cb = '0; m_zq = 1'b1; m_cbq = 1'b1;
  endtask

  task automatic model_step();
    logic zn, ld;
    logic [W-1:0] ep, ecb;
    zn  = (m_cnt == 0);
    ld  = phase_en && (sync_in || sw_sync);
    ep  = zn ? period_in : m_per;
    ecb = zn ? cmpb_in : m_cb;
    if (zn) begin m_per = period_in; m_cb = cmpb_in; end
    m_zq  = zn;
    m_cbq = (m_cnt == ecb);
    if (ld) begin
      m_cnt = phase_val;
      if (mode_sel == 2'd0) m_up = 1'b1;
      else if (mode_sel == 2'd1) m_up = 1'b0;
      else if (mode_sel == 2'd2) m_up = phase_dir_up;
    end else if (mode_sel == 2'd0) begin
      m_up = 1'b1;
      if (m_cnt < ep) m_cnt = m_cnt + 1; else m_cnt = 0;
    end else if (mode_sel == 2'd1) begin
      m_up = 1'b0;
      if (m_cnt > 0) m_cnt = m_cnt - 1; else m_cnt = ep;
    end else if (mode_sel == 2'd2) begin
      if (m_up && m_cnt < ep) m_cnt = m_cnt + 1;
      else if (m_up) begin
        m_up = 1'b0;
        if (m_cnt > 0) m_cnt = m_cnt - 1;
      end else if (m_cnt > 0) m_cnt = m_cnt - 1;
      else begin
        m_up = 1'b1;
        if (ep > 0) m_cnt = 1;
      end
    end
  endtask

  // driver: pushes the expected outputs of each cycle, then advances the model
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      obs_t e;
      logic zn;
      logic [W-1:0] ecb;
      @(negedge clk);
      #1;
      zn  = (m_cnt == 0);
      ecb = zn ? cmpb_in : m_cb;
      e.c = m_cnt;
      e.u = m_up;
      e.z = zn && !m_zq;
      e.b = (m_cnt == ecb) && !m_cbq;
      case (sync_sel)
        2'd0:    e.s = sync_in | sw_sync;
        2'd1:    e.s = e.z;
        2'd2:    e.s = e.b;
        default: e.s = 1'b0;
      endcase
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
      @(posedge clk);
      model_step();
      #1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      obs_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (cnt0 !== e.c || up0 !== e.u || zev0 !== e.z || cev0 !== e.b || so0 !== e.s) begin
        miscompares++;
        $display("FAIL %s: actual cnt=%0d up=%b z=%b b=%b s=%b expected cnt=%0d up=%b z=%b b=%b s=%b",
                 t, cnt0, up0, zev0, cev0, so0, e.c, e.u, e.z, e.b, e.s);
      end
    end
  end

  // chain monitor
  logic prev_so = 1'b0;
  always @(negedge clk) begin
    #3;
    if (rst_n && prev_so) begin
      chain_hits++;
      chk("R11 downstream count after sync", 32'(cnt1), 32'(PH1));
    end
    prev_so = rst_n ? so0 : 1'b0;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mode_sel = 2'd0; period_in = 16'd5; cmpb_in = 16'd3; phase_val = 16'd2;
    phase_en = 1'b0; phase_dir_up = 1'b0; sync_in = 1'b0; sw_sync = 1'b0;
    sync_sel = 2'd1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    // R10 reset state
    chk("R10 count", 32'(cnt0), 0);
    chk("R10 dir_up", 32'(up0), 1);
    chk("R10 zero_evt", 32'(zev0), 0);
    chk("R10 cmpb_evt", 32'(cev0), 0);
    chk("R10 sync_out", 32'(so0), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    cur_tag = "R10 first cycle"; tick(1);
    cur_tag = "R1 up count, R7 zero sync"; tick(14);
    cur_tag = "R8 compare-B sync"; sync_sel = 2'd2; tick(8);
    cur_tag = "R9 period change mid-cycle"; period_in = 16'd2; cmpb_in = 16'd1; tick(12);
    cur_tag = "R2 down count"; mode_sel = 2'd1; period_in = 16'd4; tick(14);
    cur_tag = "R3 up-down"; mode_sel = 2'd2; cmpb_in = 16'd2; tick(20);
    cur_tag = "R4 stop"; mode_sel = 2'd3; tick(5);

    cur_tag = "R5 phase load by sync_in";
    mode_sel = 2'd2; phase_en = 1'b1; phase_val = 16'd3; phase_dir_up = 1'b0;
    sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(4);
    cur_tag = "R5 phase load by sw_sync";
    phase_dir_up = 1'b1; sw_sync = 1'b1; tick(1); sw_sync = 1'b0; tick(3);
    cur_tag = "R5 sync ignored when disabled";
    phase_en = 1'b0; sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(3);
    cur_tag = "R5 phase load in up mode";
    mode_sel = 2'd0; phase_en = 1'b1; phase_val = 16'd1;
    sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(3);

    cur_tag = "R6 pass-through";
    phase_en = 1'b0; sync_sel = 2'd0;
    sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(2);
    sw_sync = 1'b1; tick(1); sw_sync = 1'b0; tick(2);
    cur_tag = "R6 output disabled"; sync_sel = 2'd3; tick(8);

    cur_tag = "R11 chain from zero";
    sync_sel = 2'd1; period_in = 16'd3; tick(16);

    @(negedge clk);
    @(negedge clk);
    chk("R11 chain syncs observed", 32'(chain_hits > 3), 1);
    finish_run();
  end

endmodule